// File: doc/BRIEF.md
# Segment Base Translator

This block turns a 32-bit segmented address, as found in a command list, into a physical memory address. Software loads a table of 16 segment bases. Each incoming address picks one base with a four-bit index taken from the middle of the address. The block adds the low 24 bits of the address to that base and returns the sum. The four most significant address bits are discarded and play no part in the result.

Addresses arrive on a valid/ready input stream and leave on a valid/ready output stream. The output is a register, so the result appears one cycle after acceptance, together with the segment index that was used. While the output holds a result that the consumer has not taken (`out_valid` high and `out_ready` low), the result stays frozen and `in_ready` is low, so no new address is accepted. When the consumer takes the result in a cycle, a new address can be accepted in that same cycle. `in_ready` is high whenever the output register is empty or is being drained.

A plain configuration port writes any table entry in one cycle and reads any entry back without delay. A table write and a translation can land in the same cycle. When they do, the translation sees the base that was in the table before the write.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and every table entry reads back as 0 through `cfg_rd_idx`/`cfg_rd_data`.
- R2: When `cfg_wr_en` is high at a clock edge, entry `cfg_wr_idx` holds `cfg_wr_data` from then on, and readback shows it after that edge. All other entries keep their values.
- R3: The segment index is address bits [27:24]. Bits [31:28] are ignored: two addresses that differ only in those bits give the same physical address and the same index.
- R4: The physical address is base[index] + {8'h00, addr[23:0]}, wrapping modulo 2^32.
- R5: An address accepted at a clock edge (`in_valid` and `in_ready` both high) puts its result on `out_valid`/`out_paddr`/`out_seg` right after that edge.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `out_paddr` and `out_seg` hold their values. When the result is taken, a waiting input is accepted in that same cycle.
- R7: If a table write and a translation that uses the same entry happen in the same cycle, the translation uses the old base. The new base applies to translations accepted from the next cycle on.
- R8: `out_seg` carries the segment index (address bits [27:24]) of the address whose result is on `out_paddr`.
- R9: With the reset table, the physical address equals the zero-extended low 24 bits of the input address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_idx | input | 4 | Entry to write |
| cfg_wr_data | input | 32 | New base value |
| cfg_rd_idx | input | 4 | Entry to read back |
| cfg_rd_data | output | 32 | Current base of the entry at `cfg_rd_idx` (combinational) |
| in_valid | input | 1 | Segmented address present |
| in_ready | output | 1 | Block can accept an address |
| in_addr | input | 32 | Segmented address |
| out_valid | output | 1 | Translation result present |
| out_ready | input | 1 | Consumer takes the result |
| out_paddr | output | 32 | Physical address |
| out_seg | output | 4 | Segment index used |

## Verification
The bench builds the block with its default parameters: a 32-bit address, the index in bits [27:24], a 24-bit offset and a 32-bit physical address. With these values it can use a base close to the top of the address space together with the largest offset, which exercises the modulo-2^32 wrap. It can also use addresses that share an index but differ in the discarded top nibble. The bench also covers a stall of several cycles followed by a handoff in the same cycle, and a write and a translation to one entry in the same cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_PA_W    = 32;
  localparam int unsigned DEF_IDX_LSB = 24;
  localparam int unsigned DEF_IDX_W   = 4;
endpackage

// File: rtl/seg_base_table.sv
module seg_base_table #(
  parameter int unsigned PA_W  = seg_xlate_pkg::DEF_PA_W,
  parameter int unsigned IDX_W = seg_xlate_pkg::DEF_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_data,
  input  logic [IDX_W-1:0] xl_idx,
  output logic [PA_W-1:0]  xl_base,
  input  logic [IDX_W-1:0] sw_idx,
  output logic [PA_W-1:0]  sw_base
);
  localparam int unsigned NUM_SEG = 1 << IDX_W;

  logic [PA_W-1:0]    base_q [NUM_SEG];
  logic [NUM_SEG-1:0] wr_hit;

  // one decoded write enable per entry
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_dec
    assign wr_hit[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SEG; i++) begin
      if (!rst_n)         base_q[i] <= '0;
      else if (wr_hit[i]) base_q[i] <= wr_data;
    end
  end

  // the read ports see the stored value, so a write in the same cycle is not yet visible (R7)
  assign xl_base = base_q[xl_idx];
  assign sw_base = base_q[sw_idx];

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> base_q[$past(wr_idx)] == $past(wr_data));

  a_r2_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
endmodule

// File: rtl/seg_xlate_stage.sv
module seg_xlate_stage #(
  parameter int unsigned ADDR_W  = seg_xlate_pkg::DEF_ADDR_W,
  parameter int unsigned PA_W    = seg_xlate_pkg::DEF_PA_W,
  parameter int unsigned IDX_LSB = seg_xlate_pkg::DEF_IDX_LSB,
  parameter int unsigned IDX_W   = seg_xlate_pkg::DEF_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic [IDX_W-1:0]  idx,
  input  logic [PA_W-1:0]   base,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PA_W-1:0]   out_paddr,
  output logic [IDX_W-1:0]  out_seg
);
  localparam int unsigned OFS_W = IDX_LSB;
  localparam int unsigned PAD_W = PA_W - OFS_W;

  logic            fire;
  logic [PA_W-1:0] ofs_ext;
  logic [PA_W-1:0] sum;

  // the index sits just above the offset, and the bits above the index are dropped (R3)
  assign idx     = in_addr[IDX_LSB +: IDX_W];
  assign ofs_ext = {{PAD_W{1'b0}}, in_addr[OFS_W-1:0]};
  assign sum     = base + ofs_ext;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_paddr <= '0;
      out_seg   <= '0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        out_paddr <= sum;
        out_seg   <= idx;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r5_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  a_r4_sum: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_paddr == PA_W'($past(base) + {{PAD_W{1'b0}}, $past(in_addr[OFS_W-1:0])}));

  a_r8_seg_tag: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_seg == $past(in_addr[IDX_LSB +: IDX_W]));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_paddr) && $stable(out_seg));

  a_r6_stall_in: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top #(
  parameter int unsigned ADDR_W  = seg_xlate_pkg::DEF_ADDR_W,
  parameter int unsigned PA_W    = seg_xlate_pkg::DEF_PA_W,
  parameter int unsigned IDX_LSB = seg_xlate_pkg::DEF_IDX_LSB,
  parameter int unsigned IDX_W   = seg_xlate_pkg::DEF_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [IDX_W-1:0]  cfg_wr_idx,
  input  logic [PA_W-1:0]   cfg_wr_data,
  input  logic [IDX_W-1:0]  cfg_rd_idx,
  output logic [PA_W-1:0]   cfg_rd_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PA_W-1:0]   out_paddr,
  output logic [IDX_W-1:0]  out_seg
);
  logic [IDX_W-1:0] xl_idx;
  logic [PA_W-1:0]  xl_base;

  seg_base_table #(.PA_W(PA_W), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_idx  (cfg_wr_idx),
    .wr_data (cfg_wr_data),
    .xl_idx  (xl_idx),
    .xl_base (xl_base),
    .sw_idx  (cfg_rd_idx),
    .sw_base (cfg_rd_data)
  );

  seg_xlate_stage #(.ADDR_W(ADDR_W), .PA_W(PA_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_addr   (in_addr),
    .idx       (xl_idx),
    .base      (xl_base),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_paddr (out_paddr),
    .out_seg   (out_seg)
  );
endmodule

// File: tb/tb_seg_xlate_top.sv
module tb_seg_xlate_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  localparam logic [31:0] V_ADDR [NV] = '{
    32'h0100_0010, 32'hF100_0010, 32'h05AB_CDEF, 32'h0FFF_FFFF,
    32'h0300_0001, 32'h2012_3456, 32'h0800_0000, 32'hA3FF_FFFF };
  localparam logic [31:0] V_PA [NV] = '{
    32'h0010_0010, 32'h0010_0010, 32'h80AB_CDEF, 32'h007F_FFFF,
    32'h0123_4561, 32'h0012_3456, 32'h0000_0000, 32'h0223_455F };
  localparam logic [3:0] V_SEG [NV] = '{
    4'd1, 4'd1, 4'd5, 4'd15, 4'd3, 4'd0, 4'd8, 4'd3 };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [3:0] cfg_wr_idx = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [3:0] cfg_rd_idx = '0;
  logic [31:0] cfg_rd_data;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_addr = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [31:0] out_paddr;
  logic [3:0] out_seg;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_top dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_paddr(out_paddr), .out_seg(out_seg));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_base(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_idx = i; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] i, input logic [31:0] exp);
    cfg_rd_idx = i;
    #1;
    chk(tag, cfg_rd_data, exp);
  endtask

  // drive one address with out_ready high, check the result after the capturing edge
  task automatic xlate(input string tag, input logic [31:0] a,
                       input logic [31:0] exp_pa, input logic [3:0] exp_seg);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " paddr"}, out_paddr, exp_pa);
    chk({tag, " seg"}, {28'd0, out_seg}, {28'd0, exp_seg});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    for (int i = 0; i < 16; i++) rd_chk("R1 table zero", 4'(i), 32'd0);

    // R9 pass-through with the reset table
    xlate("R9 passthru", 32'h7ABC_DEF0, 32'h00BC_DEF0, 4'd10);

    // R2 table load and readback
    wr_base(4'd1,  32'h0010_0000);
    wr_base(4'd5,  32'h8000_0000);
    wr_base(4'd15, 32'hFF80_0000);
    wr_base(4'd3,  32'h0123_4560);
    @(negedge clk);
    rd_chk("R2 entry1", 4'd1, 32'h0010_0000);
    rd_chk("R2 entry5", 4'd5, 32'h8000_0000);
    rd_chk("R2 entry15", 4'd15, 32'hFF80_0000);
    rd_chk("R2 entry3", 4'd3, 32'h0123_4560);
    rd_chk("R2 untouched entry8", 4'd8, 32'd0);

    // vector walk: R3 top nibble ignored, R4 base plus offset with wrap, R8 index tag
    for (int v = 0; v < NV; v++)
      xlate("R3/R4/R8 vector", V_ADDR[v], V_PA[v], V_SEG[v]);

    // R7 same-cycle write and translation to entry 3
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_idx = 4'd3; cfg_wr_data = 32'h5000_0000;
    in_valid = 1'b1; in_addr = 32'h0300_0004; out_ready = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0; in_valid = 1'b0;
    chk("R7 old base used", out_paddr, 32'h0123_4564);
    xlate("R7 new base next", 32'h0300_0004, 32'h5000_0004, 4'd3);
    rd_chk("R7 readback", 4'd3, 32'h5000_0000);

    // R6 back-pressure with handoff in the same cycle
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_addr = 32'h0100_0020;
    @(negedge clk);
    in_addr = 32'h0500_0000;
    chk("R5 valid after accept", {31'd0, out_valid}, 32'd1);
    chk("R6 in_ready low", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R6 held valid", {31'd0, out_valid}, 32'd1);
    chk("R6 held paddr", out_paddr, 32'h0010_0020);
    chk("R6 held seg", {28'd0, out_seg}, 32'd1);
    chk("R6 still stalled", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    #1;
    chk("R6 ready on drain", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 handoff paddr", out_paddr, 32'h8000_0000);
    chk("R6 handoff seg", {28'd0, out_seg}, 32'd5);
    @(negedge clk);
    chk("R5 drained", {31'd0, out_valid}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule